// File: doc/BRIEF.md
# Reset-type configuration latch

This block holds the start-up configuration word of a chip. A reset sequencer tells it when the internal reset is active and which kind of reset is running. When the internal reset is released, the block samples a 16-bit configuration port and updates its configuration register. How much of the port it takes depends on the reset kind:

- A full hardware reset takes everything.
- A short hardware reset leaves the clock setting alone.
- A software or watchdog reset refreshes only the middle field and clears part of the lower byte.

The clock-configuration bits stay opaque at the start of a hardware reset. They are taken from the port only if the reset has lasted longer than a set number of ticks. Otherwise they keep their earlier value.

The register feeds the clock generator, the bus controller and the mode logic. The upper byte is also offered as a copy that software can read. The reset kind arrives as a 3-bit code:

| Code | Reset kind |
|------|------------|
| 0 | power-on |
| 1 | long hardware |
| 2 | short hardware |
| 3 | software |
| 4 | watchdog |
| 5 to 7 | unused |

Hardware kinds are codes 0 to 2. The active cycles of a reset are the clock edges at which `rstActive` is seen high. The release edge is the first edge at which `rstActive` is seen low again after that.

Top module: `cfg_latch_top`

## Requirements
- R1: After `porN` is asserted, the configuration word is 16'hFFFF. So `cfgUpper`=8'hFF, `clkCfg`=3'b111, `wrCfg`=0 and every other field is all ones.
- R2: On release of a power-on (code 0) or long (code 1) reset that had at least OPAQUE_TICKS+1 active cycles, all 16 bits are taken from `portIn` as it stands at the release edge.
- R3: On release of a short reset (code 2), bits 15:13 keep their previous value and bits 12:0 are taken from `portIn`.
- R4: On release of a software (code 3) or watchdog (code 4) reset, bits 12:8 are taken from `portIn` and bits 7:2 are cleared. Bits 15:13 and 1:0 keep their previous value.
- R5: For hardware kinds, bits 15:13 are taken from the port only if the reset had at least OPAQUE_TICKS+1 active cycles (1025 by default). After a shorter reset they keep their previous value.
- R6: The mode pair (bit 1 adapt, bit 0 emulation) is taken only from the port value at the release edge. Port values present earlier in the reset have no effect.
- R7: The output fields are slices of the word, as follows:

  | Output | Word bits |
  |--------|-----------|
  | `cfgUpper` | 15:8 |
  | `clkCfg` | 15:13 |
  | `segSel` | 12:11 |
  | `csSel` | 10:9 |
  | `wrCfg` | inverse of bit 8 |
  | `busType` | 7:6 |
  | `bootSel` | 4 |
  | `adaptMode` | 1 |
  | `emuMode` | 0 |

- R8: Releasing a reset with codes 5 to 7 leaves the word unchanged.
- R9: The word changes only at a release edge. It holds while a reset is active and while the port changes outside a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| porN | input | 1 | Asynchronous power-up clear, active low |
| rstActive | input | 1 | Internal reset active, from the sequencer |
| rstType | input | 3 | Reset kind code, held while reset is active |
| portIn | input | 16 | Configuration port pins |
| cfgUpper | output | 8 | Software-readable copy of the upper byte |
| clkCfg | output | 3 | Clock configuration field |
| segSel | output | 2 | Segment address select field |
| csSel | output | 2 | Chip-select count field |
| wrCfg | output | 1 | Write-strobe mode, inverse of word bit 8 |
| busType | output | 2 | Bus type field |
| bootSel | output | 1 | Boot loader select |
| emuMode | output | 1 | Emulation mode bit |
| adaptMode | output | 1 | Adapt mode bit |

## Verification
Each reset drives the inverse of the release value onto the port while the reset is active. This separates sampling at the release edge from sampling earlier in the reset.

The resets are of these kinds:
- every reset code, including an unused one, each after a differently shaped previous word, so that every keep and clear mask shows up as a distinct result;
- power-on and long resets of exactly 1024 and 1025 active cycles, which pin the opaque-window boundary for the clock bits;
- very short hardware resets, which confirm the clock bits are kept.

Port toggling with no reset active, and output sampling in the middle of each reset, show that nothing moves outside a release.

// File: rtl/cfg_latch_pkg.sv
package cfg_latch_pkg;

  localparam int PORT_W = 16;

  localparam logic [2:0] KIND_POWER = 3'd0;
  localparam logic [2:0] KIND_LONG  = 3'd1;
  localparam logic [2:0] KIND_SHORT = 3'd2;
  localparam logic [2:0] KIND_SOFT  = 3'd3;
  localparam logic [2:0] KIND_WDOG  = 3'd4;

  // bits taken from the port, per reset kind
  localparam logic [PORT_W-1:0] TAKE_FULL  = 16'hFFFF;
  localparam logic [PORT_W-1:0] TAKE_SHORT = 16'h1FFF;
  localparam logic [PORT_W-1:0] TAKE_SOFT  = 16'h1F00;
  // bits forced low after software or watchdog reset
  localparam logic [PORT_W-1:0] CLEAR_SOFT = 16'h00FC;
  localparam logic [PORT_W-1:0] CFG_INIT   = 16'hFFFF;

  typedef struct packed {
    logic       latch;   // release edge: load the word
    logic       window;  // opaque interval is over
    logic [2:0] kind;    // reset kind held for this sequence
  } cfg_strobe_t;

  function automatic logic kindIsHw(input logic [2:0] k);
    return (k == KIND_POWER) || (k == KIND_LONG) || (k == KIND_SHORT);
  endfunction

endpackage

// File: rtl/cfg_latch_ctl.sv
module cfg_latch_ctl
  import cfg_latch_pkg::*;
#(
  parameter int OPAQUE_TICKS = 1024
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstActive,
  input  logic [2:0]  rstType,
  output cfg_strobe_t strobe
);

  localparam int CNT_W = $clog2(OPAQUE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(OPAQUE_TICKS);

  logic             activeQ;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       kindQ;
  logic             startSeen;
  logic             releaseSeen;
  logic             windowOpen;

  assign startSeen   = rstActive && !activeQ;
  assign releaseSeen = activeQ && !rstActive;
  assign windowOpen  = (tickCnt >= CNT_LIMIT);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      activeQ <= 1'b0;
      tickCnt <= '0;
      kindQ   <= KIND_POWER;
    end else begin
      activeQ <= rstActive;
      if (rstActive) begin
        kindQ <= rstType;
      end
      if (startSeen) begin
        tickCnt <= '0;
      end else if (rstActive && !windowOpen) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign strobe.latch  = releaseSeen;
  assign strobe.window = windowOpen;
  assign strobe.kind   = kindQ;

  AST_WINDOW_SHUT_AT_START: assert property (@(posedge clk) disable iff (!porN)
    (rstActive && !activeQ) |=> !strobe.window); // R5
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!porN)
    strobe.latch |=> !strobe.latch); // R9

endmodule

// File: rtl/cfg_latch_dp.sv
module cfg_latch_dp
  import cfg_latch_pkg::*;
#(
  parameter logic [PORT_W-1:0] OPAQUE_MASK = 16'hE000
) (
  input  logic              clk,
  input  logic              porN,
  input  cfg_strobe_t       strobe,
  input  logic [PORT_W-1:0] portIn,
  output logic [7:0]        cfgUpper,
  output logic [2:0]        clkCfg,
  output logic [1:0]        segSel,
  output logic [1:0]        csSel,
  output logic              wrCfg,
  output logic [1:0]        busType,
  output logic              bootSel,
  output logic              emuMode,
  output logic              adaptMode
);

  logic [PORT_W-1:0] cfgQ;
  logic [PORT_W-1:0] takeMask;
  logic [PORT_W-1:0] clrMask;
  logic [PORT_W-1:0] nextCfg;

  always_comb begin
    takeMask = '0;
    clrMask  = '0;
    case (strobe.kind)
      KIND_POWER, KIND_LONG: takeMask = TAKE_FULL;
      KIND_SHORT:            takeMask = TAKE_SHORT;
      KIND_SOFT, KIND_WDOG: begin
        takeMask = TAKE_SOFT;
        clrMask  = CLEAR_SOFT;
      end
      default: begin
        takeMask = '0;
        clrMask  = '0;
      end
    endcase
    if (kindIsHw(strobe.kind) && !strobe.window) begin
      takeMask = takeMask & ~OPAQUE_MASK;
    end
    nextCfg = ((cfgQ & ~takeMask) | (portIn & takeMask)) & ~clrMask;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cfgQ <= CFG_INIT;
    end else if (strobe.latch) begin
      cfgQ <= nextCfg;
    end
  end

  assign cfgUpper  = cfgQ[15:8];
  assign clkCfg    = cfgQ[15:13];
  assign segSel    = cfgQ[12:11];
  assign csSel     = cfgQ[10:9];
  assign wrCfg     = ~cfgQ[8];
  assign busType   = cfgQ[7:6];
  assign bootSel   = cfgQ[4];
  assign adaptMode = cfgQ[1];
  assign emuMode   = cfgQ[0];

  AST_HOLD_WITHOUT_RELEASE: assert property (@(posedge clk) disable iff (!porN)
    !strobe.latch |=> $stable(cfgQ)); // R9
  AST_SOFT_CLEARS_LOW: assert property (@(posedge clk) disable iff (!porN)
    (strobe.latch && (strobe.kind == KIND_SOFT || strobe.kind == KIND_WDOG))
      |=> (cfgQ[7:2] == 6'd0)); // R4
  AST_SHORT_KEEPS_CLOCK: assert property (@(posedge clk) disable iff (!porN)
    (strobe.latch && strobe.kind == KIND_SHORT) |=> $stable(cfgQ[15:13])); // R3
  AST_UNUSED_CODE_INERT: assert property (@(posedge clk) disable iff (!porN)
    (strobe.latch && strobe.kind > KIND_WDOG) |=> $stable(cfgQ)); // R8
  AST_MODE_FROM_RELEASE: assert property (@(posedge clk) disable iff (!porN)
    (strobe.latch && kindIsHw(strobe.kind)) |=> (cfgQ[1:0] == $past(portIn[1:0]))); // R6

endmodule

// File: rtl/cfg_latch_top.sv
module cfg_latch_top
  import cfg_latch_pkg::*;
#(
  parameter int                OPAQUE_TICKS = 1024,
  parameter logic [PORT_W-1:0] OPAQUE_MASK  = 16'hE000
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstActive,
  input  logic [2:0]  rstType,
  input  logic [15:0] portIn,
  output logic [7:0]  cfgUpper,
  output logic [2:0]  clkCfg,
  output logic [1:0]  segSel,
  output logic [1:0]  csSel,
  output logic        wrCfg,
  output logic [1:0]  busType,
  output logic        bootSel,
  output logic        emuMode,
  output logic        adaptMode
);

  cfg_strobe_t strobe;

  cfg_latch_ctl #(.OPAQUE_TICKS(OPAQUE_TICKS)) ctl_i (
    .clk       (clk),
    .porN      (porN),
    .rstActive (rstActive),
    .rstType   (rstType),
    .strobe    (strobe)
  );

  cfg_latch_dp #(.OPAQUE_MASK(OPAQUE_MASK)) dp_i (
    .clk       (clk),
    .porN      (porN),
    .strobe    (strobe),
    .portIn    (portIn),
    .cfgUpper  (cfgUpper),
    .clkCfg    (clkCfg),
    .segSel    (segSel),
    .csSel     (csSel),
    .wrCfg     (wrCfg),
    .busType   (busType),
    .bootSel   (bootSel),
    .emuMode   (emuMode),
    .adaptMode (adaptMode)
  );

endmodule

// File: tb/cfg_latch_top_tb_top.sv
module cfg_latch_top_tb_top;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        rstActive = 1'b0;
  logic [2:0]  rstType = 3'd0;
  logic [15:0] portIn = 16'h0000;
  logic [7:0]  cfgUpper;
  logic [2:0]  clkCfg;
  logic [1:0]  segSel;
  logic [1:0]  csSel;
  logic        wrCfg;
  logic [1:0]  busType;
  logic        bootSel;
  logic        emuMode;
  logic        adaptMode;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] VIS = 16'hFFD3;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] cyc;
    logic [15:0] rel;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd1, 16'd1100, 16'hA5C2, 16'hA5C2},  // R2 long, full take
    '{3'd2, 16'd1100, 16'h1234, 16'hB234},  // R3 short keeps 15:13
    '{3'd3, 16'd1100, 16'h0F0F, 16'hAF00},  // R4 software
    '{3'd0, 16'd1025, 16'h5A5B, 16'h5A5B},  // R5 window just open
    '{3'd1, 16'd1024, 16'hE0FF, 16'h40FF},  // R5 window just shut
    '{3'd4, 16'd50,   16'hFFFF, 16'h5F03},  // R4 watchdog
    '{3'd6, 16'd1100, 16'h0000, 16'h5F03},  // R8 unused code
    '{3'd0, 16'd10,   16'h0001, 16'h4001},  // R5 short power-on
    '{3'd2, 16'd20,   16'hFFFE, 16'h5FFE}   // R3 short reset
  };

  cfg_latch_top dut_i (
    .clk(clk), .porN(porN), .rstActive(rstActive), .rstType(rstType),
    .portIn(portIn), .cfgUpper(cfgUpper), .clkCfg(clkCfg), .segSel(segSel),
    .csSel(csSel), .wrCfg(wrCfg), .busType(busType), .bootSel(bootSel),
    .emuMode(emuMode), .adaptMode(adaptMode)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] observed();
    logic [15:0] w;
    w = '0;
    w[15:8] = cfgUpper;
    w[7:6]  = busType;
    w[4]    = bootSel;
    w[1]    = adaptMode;
    w[0]    = emuMode;
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic checkFields(input string tag);
    check(tag, {3'b0, clkCfg, segSel, csSel, wrCfg, 5'b0},
          {3'b0, cfgUpper[7:5], cfgUpper[4:3], cfgUpper[2:1], ~cfgUpper[0], 5'b0});
  endtask

  task automatic runReset(input logic [2:0] kind, input int cyc, input logic [15:0] rel,
                          input logic [15:0] prevExp, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rstType   = kind;
    rstActive = 1'b1;
    portIn    = ~rel;
    repeat (cyc) @(negedge clk);
    check("R9 hold during reset", observed() & VIS, prevExp & VIS);
    portIn    = rel;
    rstActive = 1'b0;
    @(negedge clk);
    check(tag, observed() & VIS, exp & VIS);
    portIn = 16'h0000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset word", observed() & VIS, 16'hFFFF & VIS);
    check("R1 wrCfg after reset", {15'b0, wrCfg}, 16'h0000);
    @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    check("R1 word after porN release", observed() & VIS, 16'hFFFF & VIS);
    prev = 16'hFFFF;
    for (int i = 0; i < 9; i++) begin
      runReset(VECS[i].kind, int'(VECS[i].cyc), VECS[i].rel, prev, VECS[i].exp,
               "R2 R3 R4 R5 R6 R8 vector result");
      checkFields("R7 field slices");
      prev = VECS[i].exp;
    end
    // R6: mode pair from release value only (port was inverse during reset)
    runReset(3'd1, 1100, 16'h0002, prev, 16'h0002, "R6 mode pair at release");
    check("R6 adapt/emu", {14'b0, adaptMode, emuMode}, 16'h0002);
    prev = 16'h0002;
    // R9: port toggling outside reset has no effect
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      portIn = 16'h1111 * k[15:0];
    end
    @(negedge clk);
    check("R9 idle port ignored", observed() & VIS, prev & VIS);
    // R1: asynchronous clear again
    porN = 1'b0;
    #1;
    check("R1 porN clears word", observed() & VIS, 16'hFFFF & VIS);
    @(negedge clk);
    porN = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule